// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital side of a successive-approximation analog-to-digital converter. It picks one of up to sixteen analog inputs through `mux_sel` and holds the sample-and-hold stage in sample for a fixed number of clocks. It then walks a trial code on `dac_code` from the most significant bit down to the least significant bit. The one-bit comparator answer `cmp_in` decides whether each trial bit is kept. Each finished 12-bit value is written, shifted to the top of a 16-bit word, into a register owned by the converted channel. Any register can be read back through `rd_chan`/`rd_data`.

The block has three ways of running. A single conversion converts one channel. A multi pass converts a group of one to eight consecutive channels once. A scan repeats that group pass after pass until it is stopped. One of three start sources is chosen at a time: a software start pulse, a timer trigger, or an external trigger. At the end of every completed pass the block raises a one-cycle interrupt pulse and a matching transfer-request pulse.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset `busy`, `eoc_irq`, `xfer_req` and `samp_hold` are 0 and every channel register reads 0.
- R2: Each channel conversion begins with exactly 4 clocks of `samp_hold` high. Then come 12 decision clocks, so one channel takes 16 clocks.
- R3: Decisions run from bit 11 down to bit 0. During decision k, `dac_code` is the bits kept so far with bit k set. Bit k is kept when `cmp_in` is 1, meaning the input is at or above the trial code. With an ideal comparator the result equals the input value, including the codes 0 and 4095.
- R4: The stored word is the 12-bit result in bits 15:4, and bits 3:0 read as zero.
- R5: A conversion writes only the register of the channel that was converted. All other registers keep their contents.
- R6: With `cfg_mode` = 0 (single), only channel `cfg_chan` is converted. `eoc_irq` is high in the cycle that follows the 16th rising edge after the edge that accepted the start, and `busy` is then already 0.
- R7: With `cfg_mode` = 1 (multi), channels `cfg_chan`, `cfg_chan`+1, … are converted once, `cfg_len`+1 of them, with the channel number wrapping modulo 16. There is one end-of-pass pulse, 16·(`cfg_len`+1) edges after the start.
- R8: With `cfg_mode` = 2 (scan), the group is converted repeatedly with an end-of-pass pulse every 16·(`cfg_len`+1) clocks, and `busy` stays 1. A `go_clr` pulse drops `busy` on the next edge, and the aborted conversion writes no result.
- R9: `cfg_src` selects the start: 0 `go_set`, 1 `tmr_trig`, 2 `ext_trig`, 3 none. Pulses on the sources that are not selected start nothing.
- R10: Start pulses that arrive while `busy` is 1 are ignored.
- R11: `eoc_irq` and `xfer_req` are identical one-cycle pulses, one per completed pass.
- R12: `mux_sel` does not change during the decision clocks of a channel, so the held input stays the same input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | 0 single, 1 multi, 2 scan (3 acts as single) |
| cfg_src | input | 2 | Start source: 0 software, 1 timer, 2 external, 3 none |
| cfg_chan | input | 4 | Single channel, or first channel of the group |
| cfg_len | input | 3 | Group size minus one |
| go_set | input | 1 | Software start pulse |
| go_clr | input | 1 | Stop pulse, aborts a running conversion |
| tmr_trig | input | 1 | Timer start pulse |
| ext_trig | input | 1 | External start pulse |
| cmp_in | input | 1 | Comparator: 1 when input is at or above `dac_code` |
| samp_hold | output | 1 | High while the input is being sampled |
| mux_sel | output | 4 | Analog input select |
| dac_code | output | 12 | Trial code to the comparator DAC |
| busy | output | 1 | Conversion sequence running |
| eoc_irq | output | 1 | End-of-pass interrupt pulse |
| xfer_req | output | 1 | End-of-pass transfer request pulse |
| rd_chan | input | 4 | Result register select |
| rd_data | output | 16 | Selected result register |

## Verification
The stimulus is a set of random analog levels per channel, applied through an ideal comparator model, with random modes, first channels, group sizes and start sources. Directed cases cover the codes 0, 4095, 2047 and 2048, which separate an inverted or shifted bit decision from a correct one. A group starting at channel 14 shows whether the channel number wraps. A scan with a value changed between passes, followed by an abort, separates a repeating group from a single pass and shows whether the aborted conversion leaks a write. Pulses on sources that are not selected, and pulses sent while busy, must leave the outputs and the pass timing unchanged.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_MULTI  = 2'd1,
    MODE_SCAN   = 2'd2,
    MODE_RSVD   = 2'd3
  } scan_mode_e;

  typedef enum logic [1:0] {
    SRC_SW  = 2'd0,
    SRC_TMR = 2'd1,
    SRC_EXT = 2'd2,
    SRC_OFF = 2'd3
  } start_src_e;

  // trial code for one decision: kept bits plus the bit under test
  function automatic logic [31:0] trial_code(input logic [31:0] kept, input logic [31:0] bitn);
    return kept | (32'd1 << bitn);
  endfunction

  // place a res-bit result at the top of an out_w-bit word
  function automatic logic [31:0] left_align(input logic [31:0] v, input logic [31:0] res,
                                             input logic [31:0] out_w);
    return v << (out_w - res);
  endfunction

  // channel number offset within a group, wrapping over nch inputs
  function automatic logic [31:0] wrap_chan(input logic [31:0] base, input logic [31:0] off,
                                            input logic [31:0] nch);
    return (base + off) % nch;
  endfunction

endpackage

// File: rtl/adc_start_sel.sv
module adc_start_sel
  import adc_seq_pkg::*;
(
  input  logic [1:0] src,
  input  logic       sw_go,
  input  logic       tmr_go,
  input  logic       ext_go,
  output logic       fire
);
  always_comb begin
    case (start_src_e'(src))
      SRC_SW:  fire = sw_go;
      SRC_TMR: fire = tmr_go;
      SRC_EXT: fire = ext_go;
      default: fire = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
  import adc_seq_pkg::*;
#(
  parameter int RES         = 12,
  parameter int SAMPLE_CLKS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           abort,
  input  logic           cmp,
  output logic           sampling,
  output logic           last_bit,
  output logic [RES-1:0] code,
  output logic [RES-1:0] value
);
  localparam int BIT_W  = $clog2(RES);
  localparam int SCNT_W = $clog2(SAMPLE_CLKS + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_SAMP, PH_CONV} phase_e;

  phase_e            phase;
  logic [SCNT_W-1:0] scnt;
  logic [BIT_W-1:0]  bitn;
  logic [RES-1:0]    kept;
  logic [RES-1:0]    trial;

  assign trial    = RES'(trial_code(32'(kept), 32'(bitn)));
  assign sampling = (phase == PH_SAMP);
  assign last_bit = (phase == PH_CONV) && (bitn == '0);
  assign code     = (phase == PH_CONV) ? trial : '0;
  assign value    = cmp ? trial : kept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      scnt  <= '0;
      bitn  <= '0;
      kept  <= '0;
    end else if (abort) begin
      phase <= PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_SAMP;
          scnt  <= '0;
          kept  <= '0;
        end
        PH_SAMP: if (scnt == SCNT_W'(SAMPLE_CLKS - 1)) begin
          phase <= PH_CONV;
          bitn  <= BIT_W'(RES - 1);
        end else begin
          scnt <= scnt + 1'b1;
        end
        PH_CONV: begin
          kept <= value;
          if (bitn == '0) begin
            if (start) begin
              phase <= PH_SAMP;
              scnt  <= '0;
              kept  <= '0;
            end else begin
              phase <= PH_IDLE;
            end
          end else begin
            bitn <= bitn - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NCH   = 16,
  parameter int OUT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [$clog2(NCH)-1:0] wsel,
  input  logic [OUT_W-1:0]       wdata,
  input  logic [$clog2(NCH)-1:0] rsel,
  output logic [OUT_W-1:0]       rdata
);
  logic [OUT_W-1:0] regs [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (we && (wsel == $clog2(NCH)'(g)))
        regs[g] <= wdata;
    end
  end

  assign rdata = regs[rsel];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES         = 12,
  parameter int NCH         = 16,
  parameter int SAMPLE_CLKS = 4,
  parameter int GRP_MAX     = 8,
  parameter int OUT_W       = 16,
  localparam int CH_W       = $clog2(NCH),
  localparam int LEN_W      = $clog2(GRP_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic [1:0]       cfg_src,
  input  logic [CH_W-1:0]  cfg_chan,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             go_set,
  input  logic             go_clr,
  input  logic             tmr_trig,
  input  logic             ext_trig,
  input  logic             cmp_in,
  output logic             samp_hold,
  output logic [CH_W-1:0]  mux_sel,
  output logic [RES-1:0]   dac_code,
  output logic             busy,
  output logic             eoc_irq,
  output logic             xfer_req,
  input  logic [CH_W-1:0]  rd_chan,
  output logic [OUT_W-1:0] rd_data
);
  scan_mode_e       mode_q;
  logic             run;
  logic [CH_W-1:0]  ch_q, base_q;
  logic [LEN_W-1:0] idx_q, len_q;
  logic             eoc_q;

  // named internal events
  logic             fire, accept, conv_done, pass_end, cont, core_start, core_abort;
  logic             last_bit;
  logic [RES-1:0]   conv_value;
  logic [OUT_W-1:0] wr_word;

  adc_start_sel u_src (
    .src(cfg_src), .sw_go(go_set), .tmr_go(tmr_trig), .ext_go(ext_trig), .fire(fire)
  );

  assign accept     = fire && !run;
  assign conv_done  = last_bit && run && !go_clr;
  assign pass_end   = (idx_q == len_q);
  assign cont       = conv_done && (!pass_end || (mode_q == MODE_SCAN));
  assign core_start = accept || cont;
  assign core_abort = go_clr && run;
  assign wr_word    = OUT_W'(left_align(32'(conv_value), 32'(RES), 32'(OUT_W)));

  adc_sar_core #(.RES(RES), .SAMPLE_CLKS(SAMPLE_CLKS)) u_core (
    .clk(clk), .rst_n(rst_n), .start(core_start), .abort(core_abort), .cmp(cmp_in),
    .sampling(samp_hold), .last_bit(last_bit), .code(dac_code), .value(conv_value)
  );

  adc_result_bank #(.NCH(NCH), .OUT_W(OUT_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(conv_done), .wsel(ch_q), .wdata(wr_word),
    .rsel(rd_chan), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      mode_q <= MODE_SINGLE;
      ch_q   <= '0;
      base_q <= '0;
      idx_q  <= '0;
      len_q  <= '0;
      eoc_q  <= 1'b0;
    end else begin
      eoc_q <= conv_done && pass_end;
      if (accept) begin
        run    <= 1'b1;
        mode_q <= scan_mode_e'(cfg_mode);
        ch_q   <= cfg_chan;
        base_q <= cfg_chan;
        idx_q  <= '0;
        len_q  <= (cfg_mode == MODE_MULTI || cfg_mode == MODE_SCAN) ? cfg_len : '0;
      end else if (core_abort) begin
        run <= 1'b0;
      end else if (conv_done) begin
        if (pass_end) begin
          if (mode_q == MODE_SCAN) begin
            ch_q  <= base_q;
            idx_q <= '0;
          end else begin
            run <= 1'b0;
          end
        end else begin
          ch_q  <= CH_W'(wrap_chan(32'(ch_q), 32'd1, 32'(NCH)));
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign mux_sel  = ch_q;
  assign busy     = run;
  assign eoc_irq  = eoc_q;
  assign xfer_req = eoc_q;
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
  parameter int RES         = 12,
  parameter int CH_W        = 4,
  parameter int SAMPLE_CLKS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            samp_hold,
  input logic            eoc_irq,
  input logic            xfer_req,
  input logic [CH_W-1:0] mux_sel,
  input logic [RES-1:0]  dac_code
);
  localparam int SC_W = $clog2(SAMPLE_CLKS + 2);
  logic [SC_W-1:0] samp_run;

  always_ff @(posedge clk) begin
    if (!rst_n)
      samp_run <= '0;
    else if (samp_hold && samp_run != '1)
      samp_run <= samp_run + 1'b1;
    else if (!samp_hold)
      samp_run <= '0;
  end

  p_samp_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(samp_hold) && busy) |-> (samp_run == SC_W'(SAMPLE_CLKS)));

  p_start_samples_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> samp_hold);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!samp_hold && dac_code == '0));

  p_pulse_pair_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq == xfer_req);

  p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |=> !eoc_irq);

  p_mux_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !samp_hold && $past(busy) && !$past(samp_hold)) |-> $stable(mux_sel));
endmodule

bind adc_seq_ctrl adc_seq_checker #(.RES(RES), .CH_W(CH_W), .SAMPLE_CLKS(SAMPLE_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .samp_hold(samp_hold), .eoc_irq(eoc_irq),
  .xfer_req(xfer_req), .mux_sel(mux_sel), .dac_code(dac_code)
);

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'd0, cfg_src = 2'd0;
  logic [3:0]  cfg_chan = 4'd0;
  logic [2:0]  cfg_len = 3'd0;
  logic        go_set = 1'b0, go_clr = 1'b0, tmr_trig = 1'b0, ext_trig = 1'b0;
  logic        cmp_in;
  logic        samp_hold, busy, eoc_irq, xfer_req;
  logic [3:0]  mux_sel, rd_chan = 4'd0;
  logic [11:0] dac_code;
  logic [15:0] rd_data;

  logic [11:0] vin [16];
  logic [15:0] exp_reg [16];
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  adc_seq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_src(cfg_src), .cfg_chan(cfg_chan),
    .cfg_len(cfg_len), .go_set(go_set), .go_clr(go_clr), .tmr_trig(tmr_trig),
    .ext_trig(ext_trig), .cmp_in(cmp_in), .samp_hold(samp_hold), .mux_sel(mux_sel),
    .dac_code(dac_code), .busy(busy), .eoc_irq(eoc_irq), .xfer_req(xfer_req),
    .rd_chan(rd_chan), .rd_data(rd_data)
  );

  // ideal comparator: input at or above the trial code
  assign cmp_in = (vin[mux_sel] >= dac_code);

  function automatic logic [15:0] stored_word(input logic [11:0] v);
    return {v, 4'h0};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic check_bank(input string req);
    for (int c = 0; c < 16; c++) begin
      rd_chan = 4'(c);
      #0.2;
      chk(rd_data == exp_reg[c], req, $sformatf("register %0d", c), rd_data, exp_reg[c]);
    end
  endtask

  task automatic pulse(input int src);
    @(negedge clk);
    case (src)
      0: go_set = 1'b1;
      1: tmr_trig = 1'b1;
      default: ext_trig = 1'b1;
    endcase
    @(negedge clk);
    go_set = 1'b0; tmr_trig = 1'b0; ext_trig = 1'b0;
  endtask

  // waits for the next end-of-pass pulse; cnt counts falling edges from now
  task automatic wait_eoc(output int cnt, output int scnt, output int first_mux);
    cnt = 1; scnt = 0; first_mux = mux_sel;
    while (!eoc_irq && cnt < 3000) begin
      if (samp_hold) scnt++;
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic run_group(input int mode, input int ch, input int len, input int src);
    int n, cnt, scnt, fm;
    n = (mode == 1 || mode == 2) ? len + 1 : 1;
    @(negedge clk);
    cfg_mode = 2'(mode); cfg_chan = 4'(ch); cfg_len = 3'(len); cfg_src = 2'(src);
    pulse(src);
    chk(samp_hold == 1'b1, "R2", "sampling right after start", samp_hold, 1);
    wait_eoc(cnt, scnt, fm);
    chk(fm == ch, "R6", "first channel selected", fm, ch);
    chk(cnt == 16 * n + 1, (mode == 1) ? "R7" : "R6", "end-of-pass timing", cnt, 16 * n + 1);
    chk(scnt == 4 * n, "R2", "sample clocks", scnt, 4 * n);
    chk(xfer_req == eoc_irq, "R11", "transfer request with interrupt", xfer_req, eoc_irq);
    chk(busy == 1'b0, "R6", "busy after pass", busy, 0);
    for (int i = 0; i < n; i++) exp_reg[(ch + i) % 16] = stored_word(vin[(ch + i) % 16]);
    check_bank("R5");
    @(negedge clk);
    chk(eoc_irq == 1'b0, "R11", "pulse is one cycle", eoc_irq, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    int cnt, scnt, fm, eocs;
    seed = $urandom(32'd20240611);
    for (int c = 0; c < 16; c++) begin
      vin[c] = 12'(100 * c + 7);
      exp_reg[c] = 16'h0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && eoc_irq == 0 && xfer_req == 0 && samp_hold == 0, "R1", "reset outputs",
        {busy, eoc_irq, xfer_req, samp_hold}, 0);
    check_bank("R1");

    // R3 / R4 directed corner codes, single mode
    vin[3] = 12'd0;    run_group(0, 3, 0, 0);
    vin[4] = 12'd4095; run_group(0, 4, 0, 1);
    vin[5] = 12'd2047; run_group(0, 5, 0, 2);
    vin[6] = 12'd2048; run_group(0, 6, 0, 0);
    rd_chan = 4'd4; #0.2;
    chk(rd_data == 16'hFFF0, "R4", "full scale left aligned", rd_data, 16'hFFF0);
    rd_chan = 4'd6; #0.2;
    chk(rd_data == 16'h8000, "R3", "mid code", rd_data, 16'h8000);

    // R7 wrap across the last channel
    vin[15] = 12'd1234; vin[0] = 12'd321; vin[1] = 12'd3999;
    run_group(1, 15, 2, 0);

    // R9 unselected sources start nothing
    @(negedge clk); cfg_mode = 2'd0; cfg_chan = 4'd2; cfg_src = 2'd1;
    pulse(0);
    chk(busy == 0, "R9", "software pulse with timer source", busy, 0);
    pulse(2);
    chk(busy == 0, "R9", "external pulse with timer source", busy, 0);
    cfg_src = 2'd3;
    pulse(0); pulse(1); pulse(2);
    chk(busy == 0, "R9", "no source selected", busy, 0);
    check_bank("R9");

    // R10 start pulses while busy are ignored
    @(negedge clk); cfg_src = 2'd0; cfg_chan = 4'd9; vin[9] = 12'd777;
    pulse(0);
    repeat (4) @(negedge clk);
    pulse(0);
    chk(mux_sel == 4'd9, "R10", "channel unchanged by restart", mux_sel, 9);
    eocs = 0;
    for (int k = 0; k < 60; k++) begin
      if (eoc_irq) eocs++;
      @(negedge clk);
    end
    chk(eocs == 1, "R10", "one pass only", eocs, 1);
    chk(busy == 0, "R10", "idle after ignored restart", busy, 0);
    exp_reg[9] = stored_word(12'd777);
    check_bank("R10");

    // R8 scan over 14,15,0 with a value change between passes, then abort
    @(negedge clk);
    vin[14] = 12'd50; vin[15] = 12'd60; vin[0] = 12'd70;
    cfg_mode = 2'd2; cfg_chan = 4'd14; cfg_len = 3'd2; cfg_src = 2'd2;
    pulse(2);
    wait_eoc(cnt, scnt, fm);
    chk(cnt == 49, "R8", "first pass timing", cnt, 49);
    chk(busy == 1, "R8", "busy continues in scan", busy, 1);
    vin[0] = 12'd3210;
    @(negedge clk);
    wait_eoc(cnt, scnt, fm);
    chk(cnt == 48, "R8", "second pass spacing", cnt + 0, 48);
    exp_reg[14] = stored_word(12'd50); exp_reg[15] = stored_word(12'd60);
    exp_reg[0] = stored_word(12'd3210);
    check_bank("R8");
    repeat (5) @(negedge clk);
    vin[14] = 12'd999;
    go_clr = 1'b1; @(negedge clk); go_clr = 1'b0;
    chk(busy == 0, "R8", "stop drops busy", busy, 0);
    eocs = 0;
    for (int k = 0; k < 60; k++) begin
      if (eoc_irq) eocs++;
      @(negedge clk);
    end
    chk(eocs == 0, "R8", "no pulse after stop", eocs, 0);
    check_bank("R8");

    // random runs
    for (int it = 0; it < 24; it++) begin
      int m, c0, l, s;
      for (int c = 0; c < 16; c++) vin[c] = 12'($urandom);
      m  = int'($urandom % 2);
      c0 = int'($urandom % 16);
      l  = int'($urandom % 8);
      s  = int'($urandom % 3);
      run_group(m, c0, l, s);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule